// File: doc/BRIEF.md
# Sequential 8-Bit Multiply/Divide Unit

This block is the arithmetic engine behind an accumulator machine's multiply and divide operations. It takes two unsigned byte operands, an accumulator value and a second register value. A one-cycle start strobe launches the operation, and a mode select chosen at the same time picks between multiply and divide. The unit then runs one shift step per clock for eight steps. It finishes with a one-cycle done pulse that always comes at the same cycle, whatever the operand values are.

Multiply uses shift-and-add. The 16-bit product leaves the unit split into two bytes: the new accumulator gets the low half and the new second register gets the high half. The overflow flag reports whether the product needs more than one byte. Divide uses a restoring algorithm. The quotient goes to the accumulator and the remainder to the second register. The overflow flag flags a zero divisor, and in that case both results are forced to all ones. The carry output is always low. Decoding of instructions and the architectural registers themselves live outside this unit. The caller copies the results when done is high.

Top module: `mulDivUnit`

## Requirements
- R1: After reset, busy, done, the overflow flag and both result bytes are all 0.
- R2: Suppose a start is accepted on a rising edge while the unit is idle. Done is then low after each of the next 7 edges and high after the 8th edge. It is high for exactly one cycle, and busy is low in the cycle that follows.
- R3: With mode select 0 (multiply), the accumulator result is bits 7..0 of aIn*bIn and the second result is bits 15..8.
- R4: In multiply, the overflow flag is 1 when the product exceeds 0xFF and 0 otherwise.
- R5: With mode select 1 (divide) and a nonzero divisor, the accumulator result is the integer quotient aIn/bIn, the second result is the remainder aIn%bIn, and the overflow flag is 0.
- R6: In divide with bIn equal to 0, both result bytes are 0xFF and the overflow flag is 1.
- R7: The carry output is 0 at all times, in both modes.
- R8: A start strobe that arrives while busy is high is ignored. The running operation keeps its operands, its mode and its done cycle.
- R9: After done, the result bytes and the overflow flag keep their values until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start strobe; taken only while idle |
| modeDiv | input | 1 | 0 = multiply, 1 = divide; sampled with start |
| aIn | input | 8 | Accumulator operand (multiplier or dividend) |
| bIn | input | 8 | Second operand (multiplicand or divisor) |
| busy | output | 1 | High from the accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| aOut | output | 8 | New accumulator value (product low byte or quotient) |
| bOut | output | 8 | New second register value (product high byte or remainder) |
| ovOut | output | 1 | Overflow flag (product above 0xFF, or zero divisor) |
| cyOut | output | 1 | Carry flag, always 0 |

## Verification
The hardest case to reach from the ports is a start strobe that lands in the middle of a running operation. Its operands and mode differ from the running ones, so any recapture would show up as wrong results or a shifted done pulse. The bench launches a divide, waits several step cycles, pulses start with a multiply and different bytes, and then checks that the original quotient and remainder come out at the original done cycle. The product and quotient boundaries are covered directly: 0x0F*0x11 gives exactly 0xFF, 0x10*0x10 gives exactly 0x100, and there is a zero divisor with both a zero and a nonzero dividend.

// File: rtl/mulDivPkg.sv
package mulDivPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;   // capture operands and mode
    logic step;   // advance the datapath by one shift step
  } mdStrobe_t;

endpackage

// File: rtl/mulDivCtrl.sv
module mulDivCtrl
  import mulDivPkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  output mdStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

  seqState_t        state;
  seqState_t        stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stateNext   = state;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    case (state)
      ST_IDLE: if (startIn) begin
        strobe.load = 1'b1;
        stateNext   = ST_RUN;
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (stepCnt == LAST_STEP) stateNext = ST_FIN;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.load)      stepCnt <= '0;
      else if (strobe.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R2: completion lasts a single cycle and the unit is idle right after
  a_r2_single_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R2: an accepted start is followed by stepping, never by an immediate done
  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (busy && !done));

  // R8: a start seen while running does not bring a load or drop busy
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && startIn) |-> (!strobe.load));

endmodule

// File: rtl/mulDivDpath.sv
module mulDivDpath
  import mulDivPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdStrobe_t    strobe,
  input  logic         modeDiv,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         done,
  output logic [W-1:0] aOut,
  output logic [W-1:0] bOut,
  output logic         ovOut
);

  // hiReg: product high / partial remainder; loReg: multiplier / quotient
  logic [W-1:0] hiReg;
  logic [W-1:0] loReg;
  logic [W-1:0] bReg;
  logic         divMode;
  logic         zeroDiv;

  logic [W-1:0] hiNext;
  logic [W-1:0] loNext;

  // multiply step
  logic [W:0]   mulSum;
  // divide step
  logic [W:0]   remShift;
  logic         fits;
  logic [W-1:0] remSub;

  always_comb begin
    mulSum   = {1'b0, hiReg} + (loReg[0] ? {1'b0, bReg} : '0);
    remShift = {hiReg, loReg[W-1]};
    fits     = (remShift >= {1'b0, bReg});
    remSub   = remShift[W-1:0] - bReg;
    if (divMode) begin
      hiNext = fits ? remSub : remShift[W-1:0];
      loNext = {loReg[W-2:0], fits};
    end else begin
      hiNext = mulSum[W:1];
      loNext = {mulSum[0], loReg[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg   <= '0;
      loReg   <= '0;
      bReg    <= '0;
      divMode <= 1'b0;
      zeroDiv <= 1'b0;
    end else if (strobe.load) begin
      hiReg   <= '0;
      loReg   <= aIn;
      bReg    <= bIn;
      divMode <= modeDiv;
      zeroDiv <= (bIn == '0);
    end else if (strobe.step) begin
      hiReg <= hiNext;
      loReg <= loNext;
    end
  end

  assign aOut  = (divMode && zeroDiv) ? '1 : loReg;
  assign bOut  = (divMode && zeroDiv) ? '1 : hiReg;
  assign ovOut = divMode ? zeroDiv : (hiReg != '0);

  // R5: a finished divide leaves a remainder below the divisor, OV clear
  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rstN)
    (done && divMode && (bReg != '0)) |-> ((bOut < bReg) && !ovOut));

  // R6: a zero divisor saturates both results and raises OV
  a_r6_zero_divisor: assert property (@(posedge clk) disable iff (!rstN)
    (done && divMode && (bReg == '0)) |-> ((aOut == '1) && (bOut == '1) && ovOut));

  // R3: a zero multiplicand gives a zero product
  a_r3_zero_product: assert property (@(posedge clk) disable iff (!rstN)
    (done && !divMode && (bReg == '0)) |-> ((aOut == '0) && (bOut == '0) && !ovOut));

  // R8: the second operand is not recaptured while stepping
  a_r8_operand_held: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> $stable(bReg) && $stable(divMode));

  // R9: results do not move outside load and step cycles
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> ($stable(aOut) && $stable(bOut) && $stable(ovOut)));

endmodule

// File: rtl/mulDivUnit.sv
module mulDivUnit
  import mulDivPkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         modeDiv,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] aOut,
  output logic [W-1:0] bOut,
  output logic         ovOut,
  output logic         cyOut
);

  mdStrobe_t strobe;

  mulDivCtrl #(.STEPS(W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  mulDivDpath #(.W(W)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .modeDiv (modeDiv),
    .aIn     (aIn),
    .bIn     (bIn),
    .done    (done),
    .aOut    (aOut),
    .bOut    (bOut),
    .ovOut   (ovOut)
  );

  // R7: carry is cleared by both operations in every case
  assign cyOut = 1'b0;

endmodule

// File: tb/mulDivUnit_test.sv
module mulDivUnit_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startIn = 1'b0;
  logic         modeDiv = 1'b0;
  logic [W-1:0] aIn = '0;
  logic [W-1:0] bIn = '0;
  logic         busy, done, ovOut, cyOut;
  logic [W-1:0] aOut, bOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mulDivUnit #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .modeDiv(modeDiv),
    .aIn(aIn), .bIn(bIn), .busy(busy), .done(done),
    .aOut(aOut), .bOut(bOut), .ovOut(ovOut), .cyOut(cyOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expectResult(input logic isDiv, input logic [W-1:0] a,
                              input logic [W-1:0] b, input string tag);
    int p;
    if (!isDiv) begin
      p = int'(a) * int'(b);
      chk({tag, " R3 low"},  int'(aOut), p & 'hFF);
      chk({tag, " R3 high"}, int'(bOut), (p >> 8) & 'hFF);
      chk({tag, " R4 ov"},   int'(ovOut), (p > 255) ? 1 : 0);
    end else if (b == 0) begin
      chk({tag, " R6 a"},  int'(aOut), 'hFF);
      chk({tag, " R6 b"},  int'(bOut), 'hFF);
      chk({tag, " R6 ov"}, int'(ovOut), 1);
    end else begin
      chk({tag, " R5 quot"}, int'(aOut), int'(a) / int'(b));
      chk({tag, " R5 rem"},  int'(bOut), int'(a) % int'(b));
      chk({tag, " R5 ov"},   int'(ovOut), 0);
    end
    chk({tag, " R7 carry"}, int'(cyOut), 0);
  endtask

  // start accepted on the next edge; done expected after the 8th edge beyond it
  task automatic runOp(input logic isDiv, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string tag);
    @(negedge clk);
    startIn = 1'b1; modeDiv = isDiv; aIn = a; bIn = b;
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0; aIn = ~a; bIn = ~b; modeDiv = ~isDiv;
    for (int i = 1; i < W; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 1) chk({tag, " R2 busy"}, int'(busy), 1);
      chk({tag, " R2 early done"}, int'(done), 0);
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 done"}, int'(done), 1);
    expectResult(isDiv, a, b, tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 done width"}, int'(done), 0);
    chk({tag, " R2 idle"}, int'(busy), 0);
  endtask

  task automatic tReset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 a",    int'(aOut), 0);
    chk("R1 b",    int'(bOut), 0);
    chk("R1 ov",   int'(ovOut), 0);
    chk("R7 reset carry", int'(cyOut), 0);
  endtask

  task automatic tMultiply();
    runOp(1'b0, 8'h00, 8'h55, "mul zero");
    runOp(1'b0, 8'h0F, 8'h11, "mul 0xFF edge");
    runOp(1'b0, 8'h10, 8'h10, "mul 0x100 edge");
    runOp(1'b0, 8'hFF, 8'hFF, "mul max");
    runOp(1'b0, 8'hA5, 8'h03, "mul mixed");
  endtask

  task automatic tDivide();
    runOp(1'b1, 8'd200, 8'd7, "div 200/7");
    runOp(1'b1, 8'd5, 8'd9, "div small");
    runOp(1'b1, 8'hFF, 8'h01, "div by one");
    runOp(1'b1, 8'hFF, 8'hFF, "div equal");
  endtask

  task automatic tDivZero();
    runOp(1'b1, 8'h00, 8'h00, "div 0/0");
    runOp(1'b1, 8'h3C, 8'h00, "div x/0");
  endtask

  // R8: extra start in mid-operation with different mode and operands
  task automatic tStartWhileBusy();
    @(negedge clk);
    startIn = 1'b1; modeDiv = 1'b1; aIn = 8'd250; bIn = 8'd11;
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0;
    for (int i = 1; i < W; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 3) begin
        startIn = 1'b1; modeDiv = 1'b0; aIn = 8'hFF; bIn = 8'h02;
      end else begin
        startIn = 1'b0;
      end
      chk("R8 done timing kept", int'(done), 0);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R8 done at original cycle", int'(done), 1);
    expectResult(1'b1, 8'd250, 8'd11, "R8 busy start");
    @(posedge clk);
    @(negedge clk);
    chk("R8 no second run", int'(busy), 0);
  endtask

  // R9: results persist while idle with changing inputs
  task automatic tHold();
    runOp(1'b0, 8'h21, 8'h0C, "hold setup");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      aIn = 8'(i * 37); bIn = 8'(i * 11); modeDiv = i[0];
    end
    @(negedge clk);
    chk("R9 a held",  int'(aOut), 'h8C);
    chk("R9 b held",  int'(bOut), 'h01);
    chk("R9 ov held", int'(ovOut), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMultiply();
    tDivide();
    tDivZero();
    tStartWhileBusy();
    tHold();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule